// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is one output cell of a small sum-of-products logic array. The AND plane and the configuration store sit outside it. The cell takes a set of product terms, a shared clock, an external enable pin, the level on its own pad and the level on the neighbouring pad. Two global architecture bits, shared by every cell, and two local bits belonging to this cell decide how the terms are used. They can feed a flip-flop, drive a combinational output, drive a combinational output whose enable is the first term, or leave the pad as a pure input.

The cell produces three signals. The pad level and the pad enable model the tri-state pad. The feedback signal returns to the AND plane and comes from the flip-flop, the cell's own pad or the neighbouring pad, depending on the mode. A parameter marks the two cells at the ends of the array. In those cells the global bit that steers the feedback selector is a different one.

Top module: `pal_macrocell`

## Requirements
- R1: In registered mode (cfg_g0, cfg_g1, cfg_l0) = (0, 1, 0), each rising clock edge loads the OR of all product terms into the flip-flop. pad_out follows the flip-flop and does not follow the terms between edges.
- R2: In registered mode, pad_oe equals ext_oe.
- R3: In registered mode, a non-edge cell drives fb_out from the flip-flop output, which is not inverted.
- R4: In combinational I/O mode, (0, 1, 1) or (1, 1, 1), pad_oe equals pterm[0]. The data is the OR of pterm[NUM_TERMS-1:1], so pterm[0] has no effect on pad_out. A non-edge cell feeds back own_pin.
- R5: In combinational output mode (1, 0, 0), pad_oe is 1 and the data is the OR of all terms. A non-edge cell feeds back adj_pin.
- R6: In dedicated-input mode (1, 0, 1), pad_oe is 0 and pad_out is 0. A non-edge cell feeds back adj_pin.
- R7: The unused codes (0, 0, x) and (1, 1, 0) force pad_oe to 0 and pad_out to 0, and select own_pin as feedback in every cell.
- R8: In the driving modes, cfg_l1 = 0 makes pad_out the inverse of the data and cfg_l1 = 1 makes it the data itself.
- R9: While rst is high at a rising edge, the flip-flop is cleared to 0. A registered cell with cfg_l1 = 0 then shows pad_out = 1.
- R10: An edge cell (EDGE_CELL = 1) steers its feedback selector with cfg_g0 instead of cfg_g1. Selector bit 0 picks adj_pin. Selector bit 1 picks own_pin when cfg_l0 = 1 and the flip-flop when cfg_l0 = 0. As a result, an edge cell feeds back adj_pin in registered mode and the flip-flop in combinational output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared array clock |
| rst | input | 1 | Synchronous reset of the flip-flop, active high |
| cfg_g0 | input | 1 | Global architecture bit 0 |
| cfg_g1 | input | 1 | Global architecture bit 1 |
| cfg_l0 | input | 1 | Local mode bit |
| cfg_l1 | input | 1 | Local polarity bit (1 = true, 0 = inverted) |
| pterm | input | NUM_TERMS | Product terms from the AND plane |
| ext_oe | input | 1 | External pad enable, active high |
| own_pin | input | 1 | Level observed on this cell's pad |
| adj_pin | input | 1 | Level observed on the neighbouring pad |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback into the AND plane |

## Verification
The only stored state is the flip-flop. If it holds a wrong value, a registered cell shows it at pad_out and fb_out at the next sample after the edge. A wrong mode decode shows in the same cycle as a wrong pad_oe or as feedback from the wrong source. The bench therefore sets each code with distinct levels on own_pin and adj_pin. It also drives a second instance with the edge-cell parameter, so that the feedback paths that differ between the two cells are told apart.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        MODE_REG  = 3'd0,
        MODE_CIO  = 3'd1,
        MODE_COUT = 3'd2,
        MODE_DIN  = 3'd3,
        MODE_OFF  = 3'd4
    } mc_mode_e;

    typedef enum logic [1:0] {
        FB_REG = 2'd0,
        FB_OWN = 2'd1,
        FB_ADJ = 2'd2
    } fb_src_e;

    typedef struct packed {
        logic q;
    } mc_state_t;

endpackage

// File: rtl/mc_mode_decode.sv
module mc_mode_decode
    import mc_pkg::*;
#(
    parameter bit EDGE_CELL = 1'b0
) (
    input  logic     g0,
    input  logic     g1,
    input  logic     l0,
    output mc_mode_e mode,
    output fb_src_e  fb_src
);
    logic steer;

    always_comb begin
        unique case ({g0, g1, l0})
            3'b010:  mode = MODE_REG;
            3'b011:  mode = MODE_CIO;
            3'b111:  mode = MODE_CIO;
            3'b100:  mode = MODE_COUT;
            3'b101:  mode = MODE_DIN;
            default: mode = MODE_OFF;
        endcase
    end

    // End cells steer the feedback selector with the other global bit.
    generate
        if (EDGE_CELL) begin : g_edge
            assign steer = g0;
        end else begin : g_inner
            assign steer = g1;
        end
    endgenerate

    always_comb begin
        if (mode == MODE_OFF)      fb_src = FB_OWN;
        else if (!steer)           fb_src = FB_ADJ;
        else if (l0)               fb_src = FB_OWN;
        else                       fb_src = FB_REG;
    end
endmodule

// File: rtl/mc_term_sum.sv
module mc_term_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 skip_first,
    output logic                 sum
);
    logic [NUM_TERMS-1:0] masked;

    generate
        for (genvar i = 0; i < NUM_TERMS; i++) begin : g_term
            if (i == 0) begin : g_first
                assign masked[i] = pterm[i] & ~skip_first;
            end else begin : g_rest
                assign masked[i] = pterm[i];
            end
        end
    endgenerate

    assign sum = |masked;
endmodule

// File: rtl/mc_fb_select.sv
module mc_fb_select
    import mc_pkg::*;
(
    input  fb_src_e fb_src,
    input  logic    reg_q,
    input  logic    own_pin,
    input  logic    adj_pin,
    output logic    fb
);
    always_comb begin
        unique case (fb_src)
            FB_REG:  fb = reg_q;
            FB_ADJ:  fb = adj_pin;
            default: fb = own_pin;
        endcase
    end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_TERMS = 8,
    parameter bit EDGE_CELL = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_g0,
    input  logic                 cfg_g1,
    input  logic                 cfg_l0,
    input  logic                 cfg_l1,
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 ext_oe,
    input  logic                 own_pin,
    input  logic                 adj_pin,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 fb_out
);
    mc_mode_e  mode;
    fb_src_e   fb_src;
    mc_state_t state_d, state_q;
    logic      sum_all, sum_io, data;

    mc_mode_decode #(.EDGE_CELL(EDGE_CELL)) u_dec (
        .g0(cfg_g0), .g1(cfg_g1), .l0(cfg_l0),
        .mode(mode), .fb_src(fb_src)
    );

    mc_term_sum #(.NUM_TERMS(NUM_TERMS)) u_sum_all (
        .pterm(pterm), .skip_first(1'b0), .sum(sum_all)
    );

    mc_term_sum #(.NUM_TERMS(NUM_TERMS)) u_sum_io (
        .pterm(pterm), .skip_first(1'b1), .sum(sum_io)
    );

    mc_fb_select u_fb (
        .fb_src(fb_src), .reg_q(state_q.q),
        .own_pin(own_pin), .adj_pin(adj_pin), .fb(fb_out)
    );

    always_comb begin
        state_d   = state_q;
        state_d.q = rst ? 1'b0 : sum_all;

        data   = 1'b0;
        pad_oe = 1'b0;
        unique case (mode)
            MODE_REG: begin
                data   = state_q.q;
                pad_oe = ext_oe;
            end
            MODE_CIO: begin
                data   = sum_io;
                pad_oe = pterm[0];
            end
            MODE_COUT: begin
                data   = sum_all;
                pad_oe = 1'b1;
            end
            default: begin
                data   = 1'b0;
                pad_oe = 1'b0;
            end
        endcase

        if (mode == MODE_DIN || mode == MODE_OFF) pad_out = 1'b0;
        else                                      pad_out = cfg_l1 ? data : ~data;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter int NUM_TERMS = 8,
    parameter bit EDGE_CELL = 1'b0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_g0,
    input logic                 cfg_g1,
    input logic                 cfg_l0,
    input logic                 cfg_l1,
    input logic [NUM_TERMS-1:0] pterm,
    input logic                 ext_oe,
    input logic                 own_pin,
    input logic                 adj_pin,
    input logic                 pad_out,
    input logic                 pad_oe,
    input logic                 fb_out
);
    logic [2:0] code;
    logic       is_reg, is_cio, is_cout, is_din, is_off;
    logic       past_ok_q;

    assign code    = {cfg_g0, cfg_g1, cfg_l0};
    assign is_reg  = (code == 3'b010);
    assign is_cio  = (code == 3'b011) || (code == 3'b111);
    assign is_cout = (code == 3'b100);
    assign is_din  = (code == 3'b101);
    assign is_off  = !(is_reg || is_cio || is_cout || is_din);

    always_ff @(posedge clk) past_ok_q <= !rst;

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && is_reg && $past(is_reg) && $stable(cfg_l1))
        |-> (pad_out == (cfg_l1 ? (|$past(pterm)) : ~(|$past(pterm))))); // R1

    AST_REG_OE: assert property (@(posedge clk) disable iff (rst)
        is_reg |-> (pad_oe == ext_oe)); // R2

    AST_REG_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
        (is_reg && !EDGE_CELL) |-> (fb_out == (cfg_l1 ? pad_out : ~pad_out))); // R3

    AST_CIO_OE: assert property (@(posedge clk) disable iff (rst)
        is_cio |-> (pad_oe == pterm[0])); // R4

    AST_COUT_ON: assert property (@(posedge clk) disable iff (rst)
        is_cout |-> pad_oe); // R5

    AST_DIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        is_din |-> (!pad_oe && !pad_out)); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        is_off |-> (!pad_oe && !pad_out && (fb_out == own_pin))); // R7

    AST_COUT_POLARITY: assert property (@(posedge clk) disable iff (rst)
        is_cout |-> (pad_out == (cfg_l1 ? (|pterm) : ~(|pterm)))); // R8
endmodule

bind pal_macrocell mc_checker #(.NUM_TERMS(NUM_TERMS), .EDGE_CELL(EDGE_CELL)) u_chk (.*);

// File: tb/sim_pal_macrocell.sv
module sim_pal_macrocell;
    logic       clk = 1'b0;
    logic       rst;
    logic       g0, g1, l0, l1, ext_oe, own_pin, adj_pin;
    logic [7:0] pterm;
    logic       out0, oe0, fb0, out1, oe1, fb1;
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         done     = 1'b0;

    always #2 clk = ~clk;

    pal_macrocell #(.NUM_TERMS(8), .EDGE_CELL(1'b0)) u0 (
        .clk(clk), .rst(rst), .cfg_g0(g0), .cfg_g1(g1), .cfg_l0(l0), .cfg_l1(l1),
        .pterm(pterm), .ext_oe(ext_oe), .own_pin(own_pin), .adj_pin(adj_pin),
        .pad_out(out0), .pad_oe(oe0), .fb_out(fb0)
    );

    pal_macrocell #(.NUM_TERMS(8), .EDGE_CELL(1'b1)) u1 (
        .clk(clk), .rst(rst), .cfg_g0(g0), .cfg_g1(g1), .cfg_l0(l0), .cfg_l1(l1),
        .pterm(pterm), .ext_oe(ext_oe), .own_pin(own_pin), .adj_pin(adj_pin),
        .pad_out(out1), .pad_oe(oe1), .fb_out(fb1)
    );

    // {g0,g1,l0,l1, pterm[7:0], ext_oe,own,adj, exp_out,exp_oe,exp_fb}
    localparam logic [17:0] VEC [12] = '{
        {4'b0111, 8'b0000_0011, 3'b010, 3'b111},  // R4
        {4'b0111, 8'b0000_0001, 3'b001, 3'b010},  // R4 first term ignored for data
        {4'b0110, 8'b1000_0000, 3'b110, 3'b001},  // R8 inverted, R4 oe from term 0
        {4'b1111, 8'b0100_0001, 3'b001, 3'b110},  // R4 second I/O code
        {4'b1001, 8'b0000_0001, 3'b001, 3'b111},  // R5
        {4'b1000, 8'b0000_0000, 3'b010, 3'b110},  // R5 R8
        {4'b1001, 8'b0000_0000, 3'b010, 3'b010},  // R5
        {4'b1011, 8'b1111_1111, 3'b010, 3'b000},  // R6
        {4'b1010, 8'b0000_0000, 3'b001, 3'b001},  // R6
        {4'b0001, 8'b1111_1111, 3'b110, 3'b001},  // R7
        {4'b0010, 8'b1111_1111, 3'b001, 3'b000},  // R7
        {4'b1101, 8'b1111_1111, 3'b010, 3'b001}   // R7
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] c);
        {g0, g1, l0, l1} = c;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; set_cfg(4'b0100); pterm = 8'hFF;
        ext_oe = 1'b1; own_pin = 1'b0; adj_pin = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        // R9: cleared flip-flop shows high on an inverted registered pad
        check("R9", {out0, oe0, fb0}, 3'b110);
        ext_oe = 1'b0; #1;
        check("R2", {out0, oe0}, 2'b10);

        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            set_cfg(VEC[i][17:14]);
            pterm = VEC[i][13:6];
            {ext_oe, own_pin, adj_pin} = VEC[i][5:3];
            #1;
            check($sformatf("R4-R8 vector %0d", i), {out0, oe0, fb0}, VEC[i][2:0]);
            @(negedge clk);
        end

        // Registered mode, inverted output
        set_cfg(4'b0100); ext_oe = 1'b1; own_pin = 1'b0; adj_pin = 1'b1;
        pterm = 8'b0001_0000;
        @(posedge clk); #1;
        check("R1", {out0, oe0}, 2'b01);
        check("R3", {2'b00, fb0}, 3'b001);
        check("R10 edge registered adj", {2'b00, fb1}, 3'b001);
        pterm = 8'h00; #1;
        check("R1 holds between edges", {2'b00, out0}, 3'b000);
        @(posedge clk); #1;
        check("R1", {out0, oe0, fb0}, 3'b110);
        adj_pin = 1'b0; #1;
        check("R10 edge registered adj", {2'b00, fb1}, 3'b000);

        // Registered, true polarity
        set_cfg(4'b0101); pterm = 8'b0000_0001;
        @(posedge clk); #1;
        check("R8 registered true", {out0, oe0, fb0}, 3'b111);
        ext_oe = 1'b0; #1;
        check("R2", {2'b00, oe0}, 3'b000);

        // Synchronous reset mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        check("R9", {out0, fb0}, 2'b00);
        rst = 1'b0;

        // Edge cell in combinational output mode feeds back the flip-flop
        set_cfg(4'b1001); pterm = 8'hFF; own_pin = 1'b0; adj_pin = 1'b0;
        @(posedge clk); #1;
        check("R10 edge cout reg", {out1, oe1, fb1}, 3'b111);
        check("R5 inner cout adj", {out0, oe0, fb0}, 3'b110);
        pterm = 8'h00;
        @(posedge clk); #1;
        check("R10 edge cout reg", {out1, oe1, fb1}, 3'b010);

        // Edge cell in I/O mode (0,1,1): selector bit 0 -> adjacent pin
        set_cfg(4'b0111); own_pin = 1'b1; adj_pin = 1'b0; #1;
        check("R10 edge cio adj", {2'b00, fb1}, 3'b000);
        check("R4 inner cio own", {2'b00, fb0}, 3'b001);
        // Undefined code overrides the selector in the edge cell too
        set_cfg(4'b0000); #1;
        check("R7 edge own", {out1, oe1, fb1}, 3'b001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule